// File: doc/BRIEF.md
# Palette Port Unlock and Pixel Depth Decoder

This block watches byte-wide I/O accesses aimed at a display controller. It keeps a small run counter on the palette pixel-mask port. Consecutive reads of that port advance the counter. Once the counter is full, the next write to the same port goes to a hidden DAC format register and does not change the pixel mask. The block also holds the sequencer's extended-mode depth field. It decodes that field together with bit 0 of the hidden DAC format register into the active colour depth. At the highest depth it doubles the display row offset.

A second path decodes writes to the graphics controller's mode register. It produces the write mode, the read mode and the chain-2 read enable. Whether the write mode is two or three bits wide depends on an extension bit in a separate graphics register. Surrounding logic uses these outputs to steer the pixel pipeline and the memory access paths.

Port numbers, register indices, the unlock count and the row-offset width are parameters. The defaults are:

| Port | Address |
|------|---------|
| Pixel mask | 6 |
| Sequencer index | 4 |
| Sequencer data | 5 |
| Graphics index | 14 |
| Graphics data | 15 |

Top module: `pixdepth_ctl`

## Requirements
- R1: After reset `depth_o` is 0 (8 bpp), `dac_ctrl_o` is 0, the run counter is 0, the pixel mask is 0xFF and `write_mode_o`, `read_mode_o` and `chain2_rd_o` are 0.
- R2: Each read of the pixel-mask port raises the run counter by one, up to a ceiling of UNLOCK_COUNT (4). Extra reads leave the counter at the ceiling. A write to the pixel-mask port while the counter is at the ceiling loads `dac_ctrl_o`, leaves the pixel mask unchanged and returns the counter to 0.
- R3: A write to the pixel-mask port while the counter is below the ceiling loads the pixel mask and clears the counter. Any read or write of another port also clears the counter, so the next mask write after such an access loads the mask.
- R4: The depth field is sequencer register 7, bits 3:1. `depth_o` uses this encoding: 0 = 8 bpp, 1 = 15 bpp, 2 = 16 bpp, 3 = 24 bpp, 4 = 32 bpp. Field code 0 selects 8 bpp, code 2 selects 24 bpp and code 4 selects 32 bpp.
- R5: Field codes 1 (16-bit, doubled pixel clock) and 3 (16-bit) select 16 bpp when bit 0 of the value written to the hidden register is 1, and 15 bpp when it is 0.
- R6: `depth_o` is re-decoded only in the cycle a hidden-register write completes, using the field value current at that moment. A change of the sequencer field alone does not change `depth_o`. Field codes 5, 6 and 7 leave `depth_o` unchanged.
- R7: `row_offset_o` equals `row_offset_i` times two while `depth_o` is 32 bpp. At every other depth it equals `row_offset_i`.
- R8: A write to graphics register 5 sets `write_mode_o` from data bits 2:0 if bit 2 of graphics register 0x0B is set at that time, and otherwise from data bits 1:0 with the top bit 0. The mode then holds until the next write to register 5, even if register 0x0B changes.
- R9: The same write sets `read_mode_o` from data bit 3 and `chain2_rd_o` from data bit 4.
- R10: `io_rdata` shows the pixel mask while `io_addr` selects the pixel-mask port, and 0xFF for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_addr | input | ADDR_W | Port number |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| row_offset_i | input | ROW_W | Row offset from the timing logic |
| row_offset_o | output | ROW_W+1 | Row offset adjusted for depth |
| depth_o | output | 3 | Active pixel depth code |
| dac_ctrl_o | output | 8 | Hidden DAC format register |
| write_mode_o | output | 3 | Graphics write mode |
| read_mode_o | output | 1 | Graphics read mode |
| chain2_rd_o | output | 1 | Chain-2 read enable |

## Verification
Some properties are checked by assertions on every cycle:
- the counter never exceeds its ceiling and steps by one per counted read;
- any foreign access or hidden write clears the counter;
- the depth, the hidden register and the write mode hold between their loading events;
- a narrow write mode never has its top bit set;
- the row offset is doubled exactly at 32 bpp.

Other behaviour only the bench scenarios can show. These are:
- the mapping of each field code and format bit to a particular depth;
- the routing of a write to the mask or to the hidden register after a given access history, such as saturated reads or an interrupted run;
- the write mode keeping its value across later changes of the extension register.

// File: rtl/pdd_pkg.sv
package pdd_pkg;

   typedef enum logic [2:0] {
      DEPTH_8  = 3'd0,
      DEPTH_15 = 3'd1,
      DEPTH_16 = 3'd2,
      DEPTH_24 = 3'd3,
      DEPTH_32 = 3'd4
   } depth_e;

   localparam logic [2:0] FLD_8BPP    = 3'd0;
   localparam logic [2:0] FLD_16_DCLK = 3'd1;
   localparam logic [2:0] FLD_24BPP   = 3'd2;
   localparam logic [2:0] FLD_16BPP   = 3'd3;
   localparam logic [2:0] FLD_32BPP   = 3'd4;

   typedef struct packed {
      logic   valid;
      depth_e depth;
   } depth_sel_t;

   function automatic depth_sel_t decode_depth(input logic [2:0] fld, input logic fmt565);
      depth_sel_t r;
      r.valid = 1'b1;
      r.depth = DEPTH_8;
      case (fld)
         FLD_8BPP:                 r.depth = DEPTH_8;
         FLD_16_DCLK, FLD_16BPP:   r.depth = fmt565 ? DEPTH_16 : DEPTH_15;
         FLD_24BPP:                r.depth = DEPTH_24;
         FLD_32BPP:                r.depth = DEPTH_32;
         default:                  r.valid = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pdd_unlock_seq.sv
module pdd_unlock_seq #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mask_rd,
   input  logic mask_wr,
   input  logic other_acc,
   output logic hidden_wr,
   output logic plain_wr
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] CEIL = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pdd_unlock_seq: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q;
   logic          armed;

   assign armed     = (run_q == CEIL);
   assign hidden_wr = mask_wr & armed;
   assign plain_wr  = mask_wr & ~armed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (mask_wr || other_acc)
         run_q <= '0;
      else if (mask_rd && !armed)
         run_q <= run_q + 1'b1;
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= CEIL);
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd && !mask_wr && !other_acc && !armed) |=> run_q == CW'($past(run_q) + 1'b1));
   p_hidden_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hidden_wr |=> run_q == '0);
   p_other_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      other_acc |=> run_q == '0);

endmodule

// File: rtl/pdd_depth_dec.sv
module pdd_depth_dec
   import pdd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] fld,
   input  logic       fmt565,
   output depth_e     depth
);
   depth_sel_t sel;
   depth_e     depth_q;

   assign sel   = decode_depth(fld, fmt565);
   assign depth = depth_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         depth_q <= DEPTH_8;
      else if (load && sel.valid)
         depth_q <= sel.depth;
   end

   p_depth_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(depth_q));
   p_depth_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q inside {DEPTH_8, DEPTH_15, DEPTH_16, DEPTH_24, DEPTH_32});

endmodule

// File: rtl/pdd_gfx_mode.sv
module pdd_gfx_mode #(
   parameter int IDX_W    = 8,
   parameter int MODE_IDX = 5,
   parameter int EXT_IDX  = 11,
   parameter int EXT_BIT  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wdata,
   output logic [2:0] write_mode,
   output logic       read_mode,
   output logic       chain2_rd
);
   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("pdd_gfx_mode: IDX_W must be 1..8");
      end
      if (EXT_BIT < 0 || EXT_BIT > 7) begin : g_bad_bit
         $error("pdd_gfx_mode: EXT_BIT must be 0..7");
      end
   endgenerate

   logic [IDX_W-1:0] gidx_q;
   logic             ext_q;
   logic             mode_wr;
   logic             ext_wr;
   logic [2:0]       wm_d;

   assign mode_wr = dat_wr && (gidx_q == IDX_W'(MODE_IDX));
   assign ext_wr  = dat_wr && (gidx_q == IDX_W'(EXT_IDX));
   assign wm_d    = ext_q ? wdata[2:0] : {1'b0, wdata[1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gidx_q     <= '0;
         ext_q      <= 1'b0;
         write_mode <= '0;
         read_mode  <= 1'b0;
         chain2_rd  <= 1'b0;
      end else begin
         if (idx_wr)
            gidx_q <= wdata[IDX_W-1:0];
         if (ext_wr)
            ext_q <= wdata[EXT_BIT];
         if (mode_wr) begin
            write_mode <= wm_d;
            read_mode  <= wdata[3];
            chain2_rd  <= wdata[4];
         end
      end
   end

   p_wmode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(write_mode) && $stable(read_mode) && $stable(chain2_rd));
   p_wmode_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !ext_q) |=> write_mode[2] == 1'b0);
   p_rmode_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> read_mode == $past(wdata[3]) && chain2_rd == $past(wdata[4]));

endmodule

// File: rtl/pixdepth_ctl.sv
module pixdepth_ctl
   import pdd_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int ROW_W        = 10,
   parameter int UNLOCK_COUNT = 4,
   parameter int PORT_MASK    = 6,
   parameter int PORT_SEQ_IDX = 4,
   parameter int PORT_SEQ_DAT = 5,
   parameter int PORT_GFX_IDX = 14,
   parameter int PORT_GFX_DAT = 15,
   parameter int SEQ_MODE_IDX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [ROW_W-1:0]  row_offset_i,
   output logic [ROW_W:0]    row_offset_o,
   output logic [2:0]        depth_o,
   output logic [7:0]        dac_ctrl_o,
   output logic [2:0]        write_mode_o,
   output logic              read_mode_o,
   output logic              chain2_rd_o
);
   localparam int FLD_LSB = 1;
   localparam int FLD_MSB = FLD_LSB + 2;

   generate
      if (PORT_MASK == PORT_SEQ_IDX || PORT_MASK == PORT_SEQ_DAT ||
          PORT_MASK == PORT_GFX_IDX || PORT_MASK == PORT_GFX_DAT ||
          PORT_SEQ_IDX == PORT_SEQ_DAT || PORT_GFX_IDX == PORT_GFX_DAT) begin : g_bad_ports
         $error("pixdepth_ctl: port numbers must be distinct");
      end
      if (ROW_W < 1) begin : g_bad_row
         $error("pixdepth_ctl: ROW_W must be positive");
      end
   endgenerate

   logic       any_acc;
   logic       at_mask;
   logic       mask_rd, mask_wr, other_acc;
   logic       hidden_wr, plain_wr;
   logic [7:0] seq_idx_q;
   logic [2:0] fld_q;
   logic [7:0] mask_q;
   logic [7:0] dac_q;
   depth_e     depth;

   assign any_acc   = io_wr | io_rd;
   assign at_mask   = (io_addr == ADDR_W'(PORT_MASK));
   assign mask_wr   = io_wr & at_mask;
   assign mask_rd   = io_rd & ~io_wr & at_mask;
   assign other_acc = any_acc & ~at_mask;

   pdd_unlock_seq #(.LIMIT(UNLOCK_COUNT)) u_unlock (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_rd   (mask_rd),
      .mask_wr   (mask_wr),
      .other_acc (other_acc),
      .hidden_wr (hidden_wr),
      .plain_wr  (plain_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_idx_q <= '0;
         fld_q     <= '0;
         mask_q    <= 8'hFF;
         dac_q     <= '0;
      end else begin
         if (io_wr && io_addr == ADDR_W'(PORT_SEQ_IDX))
            seq_idx_q <= io_wdata;
         if (io_wr && io_addr == ADDR_W'(PORT_SEQ_DAT) && seq_idx_q == 8'(SEQ_MODE_IDX))
            fld_q <= io_wdata[FLD_MSB:FLD_LSB];
         if (plain_wr)
            mask_q <= io_wdata;
         if (hidden_wr)
            dac_q <= io_wdata;
      end
   end

   pdd_depth_dec u_depth (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (hidden_wr),
      .fld    (fld_q),
      .fmt565 (io_wdata[0]),
      .depth  (depth)
   );

   pdd_gfx_mode u_gfx (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_wr     (io_wr && io_addr == ADDR_W'(PORT_GFX_IDX)),
      .dat_wr     (io_wr && io_addr == ADDR_W'(PORT_GFX_DAT)),
      .wdata      (io_wdata),
      .write_mode (write_mode_o),
      .read_mode  (read_mode_o),
      .chain2_rd  (chain2_rd_o)
   );

   assign depth_o      = depth;
   assign dac_ctrl_o   = dac_q;
   assign io_rdata     = at_mask ? mask_q : 8'hFF;
   assign row_offset_o = (depth == DEPTH_32) ? {row_offset_i, 1'b0} : {1'b0, row_offset_i};

   p_row_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o == 3'(DEPTH_32)) |-> row_offset_o == ((ROW_W+1)'(row_offset_i) << 1));
   p_row_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o != 3'(DEPTH_32)) |-> row_offset_o == (ROW_W+1)'(row_offset_i));
   p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hidden_wr |=> $stable(mask_q));
   p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hidden_wr |=> $stable(dac_q));

endmodule

// File: tb/test_pixdepth_ctl.sv
module test_pixdepth_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W      = 10;
   localparam int P_MASK = 6, P_SIDX = 4, P_SDAT = 5, P_GIDX = 14, P_GDAT = 15;
   localparam int WATCHDOG = 50000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             io_wr = 1'b0, io_rd = 1'b0;
   logic [3:0]       io_addr = '0;
   logic [7:0]       io_wdata = '0;
   logic [7:0]       io_rdata;
   logic [ROW_W-1:0] row_offset_i = '0;
   logic [ROW_W:0]   row_offset_o;
   logic [2:0]       depth_o;
   logic [7:0]       dac_ctrl_o;
   logic [2:0]       write_mode_o;
   logic             read_mode_o, chain2_rd_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   int m_cnt = 0, m_mask = 255, m_dac = 0, m_depth = 0, m_sidx = 0, m_fld = 0;
   int m_gidx = 0, m_ext = 0, m_wm = 0, m_rm = 0, m_c2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pixdepth_ctl #(.ROW_W(ROW_W)) i_pixdepth_ctl (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .row_offset_i(row_offset_i),
      .row_offset_o(row_offset_o), .depth_o(depth_o), .dac_ctrl_o(dac_ctrl_o),
      .write_mode_o(write_mode_o), .read_mode_o(read_mode_o), .chain2_rd_o(chain2_rd_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_rdata();
      return (io_addr == 4'(P_MASK)) ? m_mask : 255;
   endfunction

   function automatic int exp_row();
      return (m_depth == 4) ? 2 * int'(row_offset_i) : int'(row_offset_i);
   endfunction

   task automatic compare_all(input string tag);
      check(tag, "depth", int'(depth_o), m_depth);
      check(tag, "dac", int'(dac_ctrl_o), m_dac);
      check(tag, "wmode", int'(write_mode_o), m_wm);
      check(tag, "rmode", int'(read_mode_o), m_rm);
      check(tag, "chain2", int'(chain2_rd_o), m_c2);
      check(tag, "rdata", int'(io_rdata), exp_rdata());
      check(tag, "row", int'(row_offset_o), exp_row());
   endtask

   task automatic redecode(input int fmt);
      case (m_fld)
         0: m_depth = 0;
         1, 3: m_depth = (fmt & 1) ? 2 : 1;
         2: m_depth = 3;
         4: m_depth = 4;
         default: ;
      endcase
   endtask

   task automatic model_step(input bit wr, input bit rd, input int a, input int d);
      if (wr) begin
         if (a == P_MASK) begin
            if (m_cnt == 4) begin m_dac = d; redecode(d); end
            else m_mask = d;
            m_cnt = 0;
         end else begin
            m_cnt = 0;
            if (a == P_SIDX) m_sidx = d;
            if (a == P_SDAT && m_sidx == 7) m_fld = (d >> 1) & 7;
            if (a == P_GIDX) m_gidx = d;
            if (a == P_GDAT && m_gidx == 11) m_ext = (d >> 2) & 1;
            if (a == P_GDAT && m_gidx == 5) begin
               m_wm = m_ext ? (d & 7) : (d & 3);
               m_rm = (d >> 3) & 1;
               m_c2 = (d >> 4) & 1;
            end
         end
      end else if (rd) begin
         if (a == P_MASK) begin
            if (m_cnt < 4) m_cnt++;
         end else m_cnt = 0;
      end
   endtask

   // called just after a falling edge
   task automatic op(input string tag, input bit wr, input bit rd, input int a, input int d, input int row);
      io_wr = wr; io_rd = rd; io_addr = 4'(a); io_wdata = 8'(d); row_offset_i = ROW_W'(row);
      #1;
      check(tag, "rdata_pre", int'(io_rdata), exp_rdata());
      check(tag, "row_pre", int'(row_offset_o), exp_row());
      @(posedge clk);
      model_step(wr, rd, a, d);
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      #1;
      compare_all(tag);
   endtask

   task automatic unlock_write(input string tag, input int d, input int row);
      for (int i = 0; i < 4; i++) op(tag, 0, 1, P_MASK, 0, row);
      op(tag, 1, 0, P_MASK, d, row);
   endtask

   task automatic set_field(input string tag, input int d);
      op(tag, 1, 0, P_SIDX, 7, 0);
      op(tag, 1, 0, P_SDAT, d, 0);
   endtask

   initial begin
      #(WATCHDOG * CLK_PERIOD);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare_all("R1");
      // R10: other port reads 0xFF, mask reads reset value
      op("R10", 0, 1, P_SIDX, 0, 5);
      op("R10", 0, 0, P_MASK, 0, 5);
      // R3: plain mask write
      op("R3", 1, 0, P_MASK, 8'h3C, 7);
      op("R10", 0, 1, P_MASK, 0, 7);
      // R2 / R4: 32 bpp via hidden write
      set_field("R4", 8'h08);
      unlock_write("R2", 8'h00, 300);
      op("R7", 0, 0, P_SIDX, 0, 511);
      op("R7", 0, 0, P_SIDX, 0, 1023);
      // R5: 16-bit codes with format bit
      set_field("R5", 8'h06);
      unlock_write("R5", 8'h01, 100);
      unlock_write("R5", 8'h80, 100);
      set_field("R5", 8'h02);
      unlock_write("R5", 8'h41, 100);
      // R4: 24 and 8
      set_field("R4", 8'h04);
      unlock_write("R4", 8'h00, 33);
      set_field("R4", 8'h00);
      unlock_write("R4", 8'h01, 33);
      // R6: field change alone does nothing; codes 5..7 keep depth
      set_field("R6", 8'h08);
      op("R6", 0, 0, P_MASK, 0, 12);
      set_field("R6", 8'h06);
      unlock_write("R6", 8'h01, 12);
      set_field("R6", 8'h0A);
      unlock_write("R6", 8'h00, 12);
      set_field("R6", 8'h0E);
      unlock_write("R6", 8'h01, 12);
      // R3: interrupted run, then mask write
      for (int i = 0; i < 4; i++) op("R3", 0, 1, P_MASK, 0, 9);
      op("R3", 0, 1, P_GIDX, 0, 9);
      op("R3", 1, 0, P_MASK, 8'h5A, 9);
      for (int i = 0; i < 3; i++) op("R3", 0, 1, P_MASK, 0, 9);
      op("R3", 1, 0, P_MASK, 8'hA5, 9);
      // R2: saturated run still unlocks
      set_field("R2", 8'h08);
      for (int i = 0; i < 7; i++) op("R2", 0, 1, P_MASK, 0, 77);
      op("R2", 1, 0, P_MASK, 8'h11, 77);
      op("R2", 1, 0, P_MASK, 8'h22, 77);
      // R8 / R9: graphics mode
      op("R8", 1, 0, P_GIDX, 5, 0);
      op("R8", 1, 0, P_GDAT, 8'h0F, 0);
      op("R8", 1, 0, P_GIDX, 11, 0);
      op("R8", 1, 0, P_GDAT, 8'h04, 0);
      op("R8", 1, 0, P_GIDX, 5, 0);
      op("R9", 1, 0, P_GDAT, 8'h1F, 0);
      op("R8", 1, 0, P_GIDX, 11, 0);
      op("R8", 1, 0, P_GDAT, 8'h00, 0);
      op("R8", 1, 0, P_GIDX, 5, 0);
      op("R9", 1, 0, P_GDAT, 8'hE6, 0);
      op("R9", 1, 0, P_GDAT, 8'h10, 0);
      op("R8", 1, 0, P_GIDX, 6, 0);
      op("R8", 1, 0, P_GDAT, 8'hFF, 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule